// File: doc/BRIEF.md
# Single-Channel Block-Transfer Engine with Completion Interrupt

This block moves a run of words between one I/O device and a contiguous region of memory so that the CPU does not have to copy each word itself. Software sets up the transfer with three writes to slave register offsets on the system bus: the first memory address, then the number of words, then a control word with a start bit. Once started, the engine asks the bus arbiter for the memory bus. While the bus is granted it acts as bus master and alternates between the device handshake and single-word memory cycles. A single holding register carries each word between the two sides.

Two preset counters track progress. The address counter starts at the programmed address and rises by one after each word. The word counter starts at the programmed count and falls by one after each word. When the word counter runs out, the engine drops its bus request and raises an interrupt. The interrupt stays high until software reads the status register or writes the acknowledge bit. A bit in the control word selects the direction: device-to-memory or memory-to-device.

Top module: `dma_ctrl`

## Requirements
- R1: After reset `irq_o`, `bus_req_o`, `mem_en_o`, `io_rd_o` and `io_wr_o` are low. Offsets 0, 1 and 2 read back as zero.
- R2: When idle, a write to offset 0 loads the address counter and a write to offset 1 loads the word counter. Reads at those offsets return the current counter values, zero-extended. While a transfer is active, writes to offsets 0 and 1 are ignored.
- R3: With control bit 1 clear (input), each word is taken from the device and then written to memory with `mem_we_o` high. For start address X and count n, exactly the locations X to X+n-1 are written, in rising order. No other location is written.
- R4: With control bit 1 set (output), each word is read from memory at rising addresses from X. Read data returns one cycle after the `mem_en_o` cycle. Each word is then handed to the device, so the device receives the n words in address order.
- R5: After a transfer of n words, offset 0 reads X+n and offset 1 reads 0.
- R6: `bus_req_o` is high from the cycle after an accepted start until the edge that completes the last word. Memory cycles (`mem_en_o`) occur only in cycles with `bus_gnt_i` high. Each transfer makes exactly n memory cycles.
- R7: Completion sets `irq_o` on the same edge on which `bus_req_o` falls. Status at offset 2 reads bit 0 = busy, bit 1 = interrupt pending and bit 2 = direction of the last accepted start.
- R8: A pending interrupt stays high until a read of offset 2 or a write to offset 2 with bit 2 set. Either one clears it on the next edge. Reads of offsets 0 and 1 leave it high.
- R9: A start (write to offset 2 with bit 0 set) while the word counter is zero raises `irq_o` on the next edge. It makes no bus request and no memory or device cycle.
- R10: A start written while a transfer is active is ignored. The transfer in progress keeps its direction, address and count.
- R11: A device word moves only in a cycle where the strobe (`io_rd_o` or `io_wr_o`) and `io_rdy_i` are both high. While `io_rdy_i` stays low the engine holds, with busy still set.
- R12: At most one of `mem_en_o`, `io_rd_o` and `io_wr_o` is high in any cycle. Memory cycles are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_re_i | input | 1 | Register read strobe (a read of offset 2 acknowledges the interrupt) |
| cpu_addr_i | input | 2 | Register offset: 0 address, 1 count, 2 control/status |
| cpu_wdata_i | input | DW | Register write data |
| cpu_rdata_o | output | DW | Register read data (combinational) |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| mem_en_o | output | 1 | Memory cycle strobe |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid one cycle after a read cycle |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |
| io_rdy_i | input | 1 | Device ready; a word moves when strobe and ready are both high |
| io_data_i | input | DW | Data from the device |
| io_data_o | output | DW | Data to the device |
| irq_o | output | 1 | Completion interrupt |

## Verification
The main function is run across both directions with word counts of 0, 1, 2, 3 and 7. Each of these is combined with three pairings of grant and device-ready duty cycles: both always high, grant every other cycle with ready every third cycle, and the reverse. The zero count separates the immediate-completion path from a one-word transfer. The counts above one show whether the address steps up and the count steps down once per word, and not once per stall cycle. The uneven duty cycles show whether memory strobes wait for grant and device words wait for ready. Each case also checks the memory words on both sides of the target region, the readback of both counters after completion, and one of the two ways of acknowledging the interrupt. A separate case holds the device stalled mid-transfer. During the stall it fires a second start and new counter values, then shows that none of them disturbed the running transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  localparam int unsigned CTRL_GO  = 0;
  localparam int unsigned CTRL_DIR = 1;
  localparam int unsigned CTRL_ACK = 2;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_IRQ  = 1;
  localparam int unsigned STAT_DIR  = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV_RD,
    S_MEM_WR,
    S_MEM_RD,
    S_MEM_WAIT,
    S_DEV_WR
  } eng_state_e;
endpackage

// File: rtl/dma_preset_cnt.sv
module dma_preset_cnt #(
  parameter int unsigned W        = 8,
  parameter bit          COUNT_UP = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_step;

  generate
    if (COUNT_UP) begin : g_up
      assign q_step = q_q + 1'b1;
    end else begin : g_down
      assign q_step = q_q - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= load_val_i;
    else if (step_i) q_q <= q_step;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_out_i,
  input  logic          last_word_i,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          io_rdy_i,
  input  logic [DW-1:0] io_data_i,
  output logic          busy_o,
  output logic          step_o,
  output logic          done_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  output logic [DW-1:0] buf_o
);
  eng_state_e state_q, state_d;
  logic [DW-1:0] buf_q;

  always_comb begin
    state_d  = state_q;
    step_o   = 1'b0;
    mem_en_o = 1'b0;
    mem_we_o = 1'b0;
    io_rd_o  = 1'b0;
    io_wr_o  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = dir_out_i ? S_MEM_RD : S_DEV_RD;
      S_DEV_RD: begin
        io_rd_o = 1'b1;
        if (io_rdy_i) state_d = S_MEM_WR;
      end
      S_MEM_WR: begin
        mem_en_o = bus_gnt_i;
        mem_we_o = bus_gnt_i;
        if (bus_gnt_i) begin
          step_o  = 1'b1;
          state_d = last_word_i ? S_IDLE : S_DEV_RD;
        end
      end
      S_MEM_RD: begin
        mem_en_o = bus_gnt_i;
        if (bus_gnt_i) state_d = S_MEM_WAIT;
      end
      S_MEM_WAIT: state_d = S_DEV_WR;
      S_DEV_WR: begin
        io_wr_o = 1'b1;
        if (io_rdy_i) begin
          step_o  = 1'b1;
          state_d = last_word_i ? S_IDLE : S_MEM_RD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_DEV_RD && io_rdy_i) buf_q <= io_data_i;
      else if (state_q == S_MEM_WAIT)      buf_q <= mem_rdata_i;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = step_o && last_word_i;
  assign buf_o  = buf_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_we_i,
  input  logic          cpu_re_i,
  input  logic [1:0]    cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          io_rd_o,
  output logic          io_wr_o,
  input  logic          io_rdy_i,
  input  logic [DW-1:0] io_data_i,
  output logic [DW-1:0] io_data_o,
  output logic          irq_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] buf_w;
  logic busy, step, done;
  logic wr_addr, wr_cnt, wr_ctrl, go, cnt_zero, start, zero_go;
  logic irq_set, irq_clr, irq_q, dir_q;

  assign wr_addr  = cpu_we_i && cpu_addr_i == REG_ADDR && !busy;
  assign wr_cnt   = cpu_we_i && cpu_addr_i == REG_CNT  && !busy;
  assign wr_ctrl  = cpu_we_i && cpu_addr_i == REG_CTRL;
  assign go       = wr_ctrl && cpu_wdata_i[CTRL_GO] && !busy;
  assign cnt_zero = (cnt_q == '0);
  assign start    = go && !cnt_zero;
  assign zero_go  = go && cnt_zero;

  dma_preset_cnt #(.W(AW), .COUNT_UP(1'b1)) i_addr_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_addr),
    .load_val_i (cpu_wdata_i[AW-1:0]),
    .step_i     (step),
    .q_o        (addr_q)
  );

  dma_preset_cnt #(.W(DW), .COUNT_UP(1'b0)) i_word_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (cpu_wdata_i),
    .step_i     (step),
    .q_o        (cnt_q)
  );

  dma_engine #(.DW(DW)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .dir_out_i   (cpu_wdata_i[CTRL_DIR]),
    .last_word_i (cnt_q == DW'(1)),
    .bus_gnt_i   (bus_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .io_rdy_i    (io_rdy_i),
    .io_data_i   (io_data_i),
    .busy_o      (busy),
    .step_o      (step),
    .done_o      (done),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .io_rd_o     (io_rd_o),
    .io_wr_o     (io_wr_o),
    .buf_o       (buf_w)
  );

  assign irq_set = done || zero_go;
  assign irq_clr = (wr_ctrl && cpu_wdata_i[CTRL_ACK]) ||
                   (cpu_re_i && cpu_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (go)           dir_q <= cpu_wdata_i[CTRL_DIR];
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    unique case (cpu_addr_i)
      REG_ADDR: cpu_rdata_o = DW'(addr_q);
      REG_CNT:  cpu_rdata_o = cnt_q;
      REG_CTRL: begin
        cpu_rdata_o[STAT_BUSY] = busy;
        cpu_rdata_o[STAT_IRQ]  = irq_q;
        cpu_rdata_o[STAT_DIR]  = dir_q;
      end
      default:  cpu_rdata_o = '0;
    endcase
  end

  assign bus_req_o   = busy;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = buf_w;
  assign io_data_o   = buf_w;
  assign irq_o       = irq_q;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_we_i,
  input logic          cpu_re_i,
  input logic [1:0]    cpu_addr_i,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          mem_en_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          io_rd_o,
  input logic          io_wr_o,
  input logic          irq_o
);
  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!bus_req_o) begin
      seen_q <= 1'b0;
    end else if (mem_en_o) begin
      seen_q <= 1'b1;
      last_q <= mem_addr_o;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> !(mem_en_o || io_rd_o || io_wr_o));

  p_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && seen_q) |-> mem_addr_o == AW'(last_q + 1'b1));

  p_mem_gnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (bus_gnt_i && bus_req_o));

  p_done_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> irq_o);

  p_irq_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !bus_req_o && !cpu_we_i && cpu_re_i && cpu_addr_i == 2'd2) |=> !irq_o);

  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cpu_we_i && !cpu_re_i) |=> irq_o);

  p_one_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_en_o, io_rd_o, io_wr_o}) <= 1);

  p_mem_spaced_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> !mem_en_o);
endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW)) i_dma_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_we_i   (cpu_we_i),
  .cpu_re_i   (cpu_re_i),
  .cpu_addr_i (cpu_addr_i),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .mem_en_o   (mem_en_o),
  .mem_addr_o (mem_addr_o),
  .io_rd_o    (io_rd_o),
  .io_wr_o    (io_wr_o),
  .irq_o      (irq_o)
);

// File: tb/test_dma_ctrl.sv
`timescale 1ns/1ps
module test_dma_ctrl;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cpu_we_i = 1'b0, cpu_re_i = 1'b0;
  logic [1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic bus_req_o, bus_gnt_i, mem_en_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, io_data_i, io_data_o;
  logic io_rd_o, io_wr_o, io_rdy_i, irq_o;

  dma_ctrl #(.DW(DW), .AW(AW)) i_dma_ctrl (.*);

  always #4 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int gnt_mode = 0, rdy_mode = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic duty(int mode, int c, int ph);
    case (mode)
      0: return 1'b1;
      1: return ((c + ph) % 2) == 0;
      2: return ((c + ph) % 3) == 0;
      default: return 1'b0;
    endcase
  endfunction
  assign bus_gnt_i = duty(gnt_mode, cyc, 0);
  assign io_rdy_i  = duty(rdy_mode, cyc, 1);

  function automatic logic [DW-1:0] src_word(int k);
    return 16'hA500 ^ 16'(k * 7 + 1);
  endfunction
  function automatic logic [DW-1:0] mem_pat(int a);
    return 16'h3C00 + 16'(a * 5);
  endfunction

  // memory and device models
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] sink [0:63];
  int mem_cyc = 0, bad_cyc = 0, src_idx = 0, sink_n = 0;
  assign io_data_i = src_word(src_idx);

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      mem_cyc <= mem_cyc + 1;
      if (!bus_gnt_i) bad_cyc <= bad_cyc + 1;
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o];
    end
    if (io_rd_o && io_rdy_i) src_idx <= src_idx + 1;
    if (io_wr_o && io_rdy_i) begin
      sink[sink_n[5:0]] <= io_data_o;
      sink_n <= sink_n + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk_i);
    cpu_we_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    cpu_re_i = 1'b1; cpu_addr_i = a;
    #1 d = cpu_rdata_o;
    @(negedge clk_i);
    cpu_re_i = 1'b0;
  endtask

  task automatic wait_irq(int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i);
      if (irq_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic prep(int gm, int rm);
    @(negedge clk_i);
    gnt_mode = gm; rdy_mode = rm;
    src_idx = 0; sink_n = 0; mem_cyc = 0; bad_cyc = 0;
    for (int i = 0; i < 256; i++) mem[i] = mem_pat(i);
  endtask

  task automatic run_case(bit dir_out, int x, int n, int gm, int rm, bit ack_by_write);
    logic [DW-1:0] rd;
    bit ok;
    prep(gm, rm);
    cpu_wr(2'd0, DW'(x));
    cpu_wr(2'd1, DW'(n));
    cpu_rd(2'd0, rd); chk("R2 addr load", rd, x);
    cpu_rd(2'd1, rd); chk("R2 count load", rd, n);
    cpu_wr(2'd2, DW'({dir_out, 1'b1}));
    if (n == 0) begin
      chk("R9 zero-count irq", irq_o, 1);
      chk("R9 zero-count no request", bus_req_o, 0);
      repeat (4) @(negedge clk_i);
      chk("R9 zero-count no mem cycle", mem_cyc, 0);
      chk("R9 zero-count no device word", src_idx + sink_n, 0);
    end else begin
      wait_irq(2000, ok);
      chk("R7 completion irq", ok, 1);
      chk("R6 request released at done", bus_req_o, 0);
      chk("R6 memory cycles = n", mem_cyc, n);
      chk("R6 no cycle without grant", bad_cyc, 0);
    end
    cpu_rd(2'd0, rd); chk("R5 final address", rd, (x + n) & 255);
    cpu_rd(2'd1, rd); chk("R5 final count", rd, 0);
    chk("R8 irq held over counter reads", irq_o, 1);
    if (ack_by_write) begin
      cpu_wr(2'd2, DW'(4));
      chk("R8 ack write clears irq", irq_o, 0);
    end else begin
      cpu_rd(2'd2, rd);
      chk("R7 status busy/irq/dir", rd, {dir_out, 2'b10});
      chk("R8 status read clears irq", irq_o, 0);
    end
    if (!dir_out) begin
      for (int k = 0; k < n; k++) chk("R3 word written", mem[x + k], src_word(k));
      if (x > 0) chk("R3 below region untouched", mem[x - 1], mem_pat(x - 1));
      chk("R3 above region untouched", mem[x + n], mem_pat(x + n));
      chk("R3 device words taken", src_idx, n);
    end else begin
      chk("R4 device word count", sink_n, n);
      for (int k = 0; k < n; k++) chk("R4 word delivered", sink[k], mem_pat(x + k));
      chk("R4 no device read", src_idx, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd;
    bit ok;
    int nl [5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk_i);
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset request", bus_req_o, 0);
    chk("R1 reset strobes", {mem_en_o, io_rd_o, io_wr_o}, 0);
    rst_ni = 1'b1;
    cpu_rd(2'd0, rd); chk("R1 reset address reg", rd, 0);
    cpu_rd(2'd1, rd); chk("R1 reset count reg", rd, 0);
    cpu_rd(2'd2, rd); chk("R1 reset status", rd, 0);

    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 5; i++)
        for (int m = 0; m < 3; m++)
          run_case(d[0], 16 * i + 64 * d + 3 * m, nl[i], m, (3 - m) % 3, (i + m) % 2 == 1);

    // stalled output transfer: second start and counter writes must be ignored
    prep(1, 3);
    cpu_wr(2'd0, DW'(8'h80));
    cpu_wr(2'd1, DW'(4));
    cpu_wr(2'd2, DW'(3));
    repeat (10) @(negedge clk_i);
    cpu_rd(2'd2, rd); chk("R11 busy while device stalled", rd, 16'h5);
    chk("R11 no device word while not ready", sink_n, 0);
    chk("R6 request held while busy", bus_req_o, 1);
    cpu_wr(2'd0, DW'(8'h11));
    cpu_wr(2'd1, DW'(9));
    cpu_wr(2'd2, DW'(1));
    cpu_rd(2'd0, rd); chk("R2 address write ignored while busy", rd, 8'h80);
    cpu_rd(2'd1, rd); chk("R2 count write ignored while busy", rd, 4);
    @(negedge clk_i); rdy_mode = 0;
    wait_irq(2000, ok);
    chk("R10 transfer completes", ok, 1);
    chk("R10 original length kept", sink_n, 4);
    for (int k = 0; k < 4; k++) chk("R10 original data kept", sink[k], mem_pat(8'h80 + k));
    chk("R10 no input transfer started", src_idx, 0);
    cpu_rd(2'd2, rd); chk("R10 direction kept", rd, 16'h6);
    cpu_rd(2'd0, rd); chk("R10 final address", rd, 8'h84);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule